// File: doc/BRIEF.md
# Lockable Watchdog Timer

A 16-bit down-counter driven by a slow clock enable (nominally 32.768 kHz) through a selectable divider of 1, 16 or 256. In plain timer mode it counts from a programmed start value to zero, reloads itself and raises an interrupt on every wrap. In watchdog mode it must be serviced by a write to its service register before it reaches zero. If it is not serviced in time, it either pulses a reset request to the system reset controller or raises the interrupt, depending on a control bit.

Software programs the start value first and then sets the watchdog enable bit. The counter takes the start value at the moment counting is enabled. From then on the start value and the control register are frozen, and only a system reset can release them. With the /256 divider and a full-scale start value, the timeout is about 512 seconds.

The register bus is a plain single-cycle write port with a combinational read mux. It has no data stream, so no valid/ready handshake is used. Register map, by word address on `bus_addr`: 0 start value, 1 live count (read-only), 2 control, 3 service.

Top module: `guard_timer`

## Requirements
- R1: After reset the start value reads 0x0000, the count reads 0xFFFF, the control register reads 0x0000, and `irq` and `rst_req` are low.
- R2: With control bit 4 (plain run) set, the count drops by one on each divided tick. A divided tick at count 0 instead reloads the start value and sets `irq`.
- R3: Control bits [3:2] select the divider: 00 gives /1, 01 gives /16, and 10 or 11 give /256. The divider restarts whenever counting starts or a service write occurs.
- R4: Writing control with bit 5 (watchdog) or bit 4 set while neither was set loads the count from the start value held before that write. Counting begins on the next divided tick.
- R5: In watchdog mode with control bit 1 clear, a divided tick at count 0 gives a `rst_req` pulse exactly one cycle wide and reloads the count.
- R6: In watchdog mode with control bit 1 set, a timeout sets `irq`. `irq` stays high until a service write, and the count reloads and keeps running.
- R7: A write of any value to address 3 reloads the count from the start value and clears `irq`. A service write in the last cycle before expiry prevents the timeout.
- R8: While control bit 5 is set, writes to the start value and to the control register are ignored. Only reset leaves watchdog mode.
- R9: Writes to address 1 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | slow clock enable, one cycle per slow period |
| bus_we | input | 1 | register write strobe |
| bus_addr | input | 2 | register word address |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data for `bus_addr` |
| irq | output | 1 | timer interrupt, held until serviced |
| rst_req | output | 1 | one-cycle system reset request |

## Verification
Three stimulus patterns are used. With an unserviced watchdog, the timeout point and the reset-versus-interrupt choice are observed. With service writes placed one cycle before expiry, the bench tells an on-time service apart from a late one. With the divider set to /16 and /256 and a start value of 1, the exact cycle of the first decrement shows which divisor was applied. Writes to locked or read-only registers are followed by read-backs, so any ignored write that changed state is visible. A behavioural model tracks the count, `irq` and `rst_req` on every clock.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD    = 2'd0,
    A_COUNT   = 2'd1,
    A_CTRL    = 2'd2,
    A_SERVICE = 2'd3
  } addr_e;

  // control layout: [5] watchdog, [4] run, [3:2] divider, [1] irq-on-timeout, [0] reserved
  typedef struct packed {
    logic       wd;
    logic       run;
    logic [1:0] psel;
    logic       act_irq;
    logic       rsv;
  } ctrl_t;
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clear,
  input  logic [1:0] psel,
  output logic       step
);
  logic [HI_LOG2-1:0] pre_q;
  logic mid_full, hi_full;

  assign mid_full = &pre_q[MID_LOG2-1:0];
  assign hi_full  = &pre_q;

  always_comb begin
    unique case (psel)
      2'b00:   step = tick;
      2'b01:   step = tick & mid_full;
      default: step = tick & hi_full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pre_q <= '0;
    else if (clear) pre_q <= '0;
    else if (tick)  pre_q <= pre_q + 1'b1;
  end

  // R3: after a clear, no divided step can appear before any tick has been seen
  p_clear_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] load_q,
  output ctrl_t        ctrl_q,
  output logic         start
);
  ctrl_t ctrl_new;
  logic  locked;

  assign locked   = ctrl_q.wd;
  assign ctrl_new = ctrl_t'({wdata[CTRL_W-1:1], 1'b0});
  assign start    = wr_ctrl & ~locked & ~(ctrl_q.run | ctrl_q.wd) &
                    (ctrl_new.run | ctrl_new.wd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else if (!locked) begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= ctrl_new;
    end
  end

  // R8: watchdog mode is sticky and freezes both writable registers
  p_wd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.wd |=> ctrl_q.wd);
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.wd |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wd,
  input  logic         act_irq,
  input  logic         step,
  input  logic         start,
  input  logic         service,
  input  logic [W-1:0] load,
  output logic [W-1:0] count,
  output logic         irq,
  output logic         rst_req
);
  logic active, at_zero, timeout, to_reset;

  assign active   = run | wd;
  assign at_zero  = (count == '0);
  assign timeout  = active & step & at_zero & ~service;
  assign to_reset = timeout & wd & ~act_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '1;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= to_reset;
      if (service)                   count <= load;
      else if (start)                count <= load;
      else if (active && step)       count <= at_zero ? load : count - 1'b1;
      if (service)                   irq <= 1'b0;
      else if (timeout && !to_reset) irq <= 1'b1;
    end
  end

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !service) |=> irq);
  p_svc_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> (count == $past(load) && !irq));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !at_zero && !service) |=>
      (count == $past(count) - {{(W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int PRE_MID_LOG2 = 4,
  parameter int PRE_HI_LOG2  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq,
  output logic             rst_req
);
  logic             wr_load, wr_ctrl, service, start, step;
  logic [CNT_W-1:0] load_q, count;
  ctrl_t            ctrl_q;

  assign wr_load = bus_we & (bus_addr == A_LOAD);
  assign wr_ctrl = bus_we & (bus_addr == A_CTRL);
  assign service = bus_we & (bus_addr == A_SERVICE);

  gt_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .load_q(load_q), .ctrl_q(ctrl_q), .start(start)
  );

  gt_prescaler #(.MID_LOG2(PRE_MID_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(service | start),
    .psel(ctrl_q.psel), .step(step)
  );

  gt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .wd(ctrl_q.wd),
    .act_irq(ctrl_q.act_irq), .step(step), .start(start), .service(service),
    .load(load_q), .count(count), .irq(irq), .rst_req(rst_req)
  );

  always_comb begin
    unique case (bus_addr)
      A_LOAD:  bus_rdata = load_q;
      A_COUNT: bus_rdata = count;
      A_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      default: bus_rdata = '0;
    endcase
  end

  // R9: the live count never takes bus data through its own address
  p_count_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_COUNT && !step) |=> $stable(count));
endmodule

// File: tb/tb_guard_timer.sv
module tb_guard_timer;
  logic        clk = 0, rst_n = 0, tick = 1, bus_we = 0;
  logic [1:0]  bus_addr = 2'd1;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        irq, rst_req;
  int checks = 0, errors = 0, rst_seen = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  guard_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  // behavioural reference model
  logic [15:0] m_load, m_cnt; logic [5:0] m_ctrl, m_new; int m_pre;
  bit m_irq, m_rst, m_run, m_step, m_rnext;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = 0; m_cnt = 16'hFFFF; m_ctrl = 0; m_pre = 0; m_irq = 0; m_rst = 0;
    end else begin
      m_run = m_ctrl[4] | m_ctrl[5];
      case (m_ctrl[3:2])
        2'b00: m_step = tick;
        2'b01: m_step = tick && (m_pre % 16 == 15);
        default: m_step = tick && (m_pre == 255);
      endcase
      m_rnext = 0;
      if (bus_we && bus_addr == 3) begin
        m_cnt = m_load; m_pre = 0; m_irq = 0;
      end else begin
        if (tick) m_pre = (m_pre + 1) % 256;
        if (m_run && m_step) begin
          if (m_cnt == 0) begin
            m_cnt = m_load;
            if (m_ctrl[5] && !m_ctrl[1]) m_rnext = 1; else m_irq = 1;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (bus_we && !m_ctrl[5]) begin
        if (bus_addr == 2) begin
          m_new = bus_wdata[5:0] & 6'h3E;
          if (!m_run && (m_new[4] || m_new[5])) begin m_cnt = m_load; m_pre = 0; end
          m_ctrl = m_new;
        end else if (bus_addr == 0) m_load = bus_wdata;
      end
      m_rst = m_rnext;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n && !done) begin
      if (rst_req) rst_seen++;
      check("R5/R6 model irq", irq, m_irq);
      check("R5 model rst_req", rst_req, m_rst);
      if (bus_addr == 1 && !bus_we) check("R2 model count", bus_rdata, m_cnt);
    end
    if (cyc > 100000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); bus_we = 1; bus_addr = a[1:0]; bus_wdata = d[15:0];
    @(negedge clk); bus_we = 0; bus_addr = 2'd1;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); bus_addr = a[1:0]; #2; v = bus_rdata;
    bus_addr = 2'd1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  int v, base;
  initial begin
    do_reset();
    rd(0, v); check("R1 load reset", v, 0);
    rd(1, v); check("R1 count reset", v, 16'hFFFF);
    rd(2, v); check("R1 ctrl reset", v, 0);
    #2; check("R1 irq reset", irq, 0); check("R1 rst_req reset", rst_req, 0);
    wr(1, 16'h1234);
    rd(1, v); check("R9 count read-only", v, 16'hFFFF);

    // watchdog, reset action
    wr(0, 6); wr(2, 'h20);
    rd(1, v); check("R4 start value latched", v, 5);
    wr(3, 'hAB);
    rd(1, v); check("R7 service reload", v, 5);
    base = rst_seen;
    for (int i = 0; i < 5; i++) begin
      wr(3, i);
      repeat (5) @(negedge clk);
    end
    #2; check("R7 service before expiry", rst_seen - base, 0);
    base = rst_seen;
    for (int i = 0; i < 20 && rst_seen == base; i++) @(negedge clk);
    #2; check("R5 reset request seen", rst_seen - base, 1);
    @(negedge clk); #2; check("R5 pulse one cycle", rst_req, 0);
    wr(0, 'h55); wr(2, 'h00);
    rd(0, v); check("R8 load locked", v, 6);
    rd(2, v); check("R8 ctrl locked", v, 'h20);

    // only reset leaves watchdog; interrupt action
    do_reset();
    rd(2, v); check("R8 reset leaves watchdog", v, 0);
    wr(0, 4); wr(2, 'h22);
    for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
    #2; check("R6 irq raised", irq, 1);
    repeat (10) @(negedge clk);
    #2; check("R6 irq held", irq, 1); check("R6 no reset request", rst_req, 0);
    wr(3, 0);
    #2; check("R7 service clears irq", irq, 0);

    // plain run mode
    do_reset();
    wr(0, 3); wr(2, 'h10);
    repeat (3) @(negedge clk);
    #2; check("R2 no irq before wrap", irq, 0);
    @(negedge clk); #2; check("R2 irq on wrap", irq, 1);
    rd(1, v); check("R2 reload after wrap", v, 2);

    // divider /16 then /256
    wr(2, 0); wr(3, 0); wr(0, 1); wr(2, 'h14);
    repeat (14) @(negedge clk);
    rd(1, v); check("R3 /16 holds", v, 1);
    rd(1, v); check("R3 /16 steps", v, 0);
    wr(2, 0); wr(2, 'h1C);
    repeat (254) @(negedge clk);
    rd(1, v); check("R3 /256 holds", v, 1);
    rd(1, v); check("R3 /256 steps", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule